// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor request port and a slower word-wide backing memory. Each processor address is cut into a tag, a set index and a word offset. The index picks one set. Both ways of that set are compared against the tag in the same cycle, and a hit returns the addressed word one cycle after the request is accepted. On a miss the controller picks a victim way. An empty way is chosen first, lowest number first. If both ways are full, the less recently used way is chosen. If needed, the controller first copies a modified victim out to memory. It then fetches the whole block, installs it and answers the request.

The write policy is fixed at build time. In write-back mode, writes stay in the cache and mark the block dirty. A write miss fetches the block and merges the new word into it. In write-through mode, every write goes to memory. A write hit also updates the cached copy, and a write miss does not allocate. Two counters report how many accepted requests hit and how many missed.

The processor side uses a valid/ready handshake. `cpu_ready` drops while a miss or a memory write is in progress. A single-cycle `resp_valid` pulse marks the completion of every request. For a read, `resp_rdata` carries the data. The memory side is a request/acknowledge interface. The request and its fields are held until a one-cycle acknowledge, and read data arrives together with that acknowledge.

Top module: `cache2w_ctrl`

## Requirements
- R1: A read hit accepted at a clock edge raises `resp_valid` for exactly the following cycle, carrying the word at the request's offset. `cpu_ready` stays high, so hits can follow back to back.
- R2: A request hits only when a way of the indexed set is valid and holds a matching tag. At most one way ever matches.
- R3: On a miss, a way whose valid bit is clear receives the new block. When both ways are clear, way 0 is used.
- R4: On a miss with both ways valid, the way marked least recently used is replaced. One recency bit is kept per set.
- R5: Every read hit, write hit and fill makes the touched way the most recently used in its set.
- R6: In write-back mode, a write hit completes with the one-cycle hit timing. It changes only the cached word, sets the block's dirty bit and issues no memory write.
- R7: In write-back mode, a dirty victim's words are written to memory before the refill read starts, so the data is never lost.
- R8: In write-through mode, every write updates the memory word. A write hit also updates the cached word.
- R9: In write-through mode, a write miss writes memory only and leaves the cache contents and the recency state unchanged.
- R10: In write-back mode, a write miss fetches the block, merges the written word and installs the block as dirty.
- R11: During a miss or a memory write, `cpu_ready` stays low until the memory work is done. Memory traffic only starts on the cycle after a request is accepted.
- R12: Every accepted request adds exactly one to either `hit_count` or `miss_count`. Neither counter changes when no request is accepted.
- R13: Reset (active-low, synchronous) clears all valid, dirty and recency bits and both counters, and leaves `cpu_ready` high.
- R14: With two sets of two one-word ways, the word-address trace 0,2,0,1,4,0,2,3,5,4 gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss. From reset, the trace 0,2,0,4,2 gives miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle pulse when a request completes |
| resp_rdata | output | DATA_W | Read data, valid with resp_valid |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| hit_count | output | CNT_W | Accepted requests that hit |
| miss_count | output | CNT_W | Accepted requests that missed |

## Verification
The embedded properties watch several behaviours on every cycle:
- at most one way of the indexed set ever matches;
- an accepted hit answers on the next cycle;
- the counters advance exactly once per acceptance;
- memory traffic only begins right after an acceptance;
- a dirty victim is never refilled without first being written out;
- in write-back mode, memory writes happen only during an eviction;
- a fill leaves the filled way most recently used.

The scenarios are needed for the behaviours that depend on a history of accesses. These are the exact hit/miss patterns of the two fixed traces and LRU replacement over long mixed sequences. They also include the returned data compared against a shadow of memory, and the memory contents after write-through writes and after a dirty eviction. The no-allocate behaviour of write-through write misses is shown the same way.

// File: rtl/cache2w_pkg.sv
// Package: shared constants and the controller state type.
// Assumes: exactly two ways; the state encoding is private to the controller.
package cache2w_pkg;
    localparam int NWAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } cstate_t;
endpackage

// File: rtl/cache2w_tag_cmp.sv
// Module: parallel tag comparison, one comparator per way.
// Assumes: the caller presents the stored tags and valid bits of one set.
module cache2w_tag_cmp
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0]             tag_in,
    input  logic [NWAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [NWAYS-1:0]             set_valid,
    output logic [NWAYS-1:0]             way_hit,
    output logic                         hit_any,
    output logic                         hit_way
);
    // One comparator per way, gated by that way's valid bit.
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign way_hit[w] = set_valid[w] && (set_tags[w] == tag_in);
    end

    assign hit_any = |way_hit;
    assign hit_way = way_hit[1];
endmodule

// File: rtl/cache2w_victim.sv
// Module: victim way selection for one set.
// Assumes: lru_way names the way that was used less recently.
module cache2w_victim
    import cache2w_pkg::*;
(
    input  logic [NWAYS-1:0] set_valid,
    input  logic             lru_way,
    output logic             victim
);
    // An empty way wins (lowest first); otherwise the LRU way.
    always_comb begin
        if (!set_valid[0])      victim = 1'b0;
        else if (!set_valid[1]) victim = 1'b1;
        else                    victim = lru_way;
    end
endmodule

// File: rtl/cache2w_ctrl.sv
// Module: two-way set-associative cache controller (top).
// Holds tags, data, valid/dirty/LRU state and the miss sequencer.
// Assumes: memory holds each request until a one-cycle ack; read data comes with ack.
// WRITE_BACK=1 selects write-back with write-allocate; 0 selects write-through, no allocate.
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int SET_W      = 1,
    parameter int BLK_WORDS  = 1,
    parameter bit WRITE_BACK = 1'b1,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS   = 1 << SET_W;
    localparam int OFF_W  = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 0;
    localparam int OFF_WS = (OFF_W > 0) ? OFF_W : 1;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    // Storage
    logic [TAG_W-1:0]  tag_q  [SETS][NWAYS];
    logic [DATA_W-1:0] data_q [SETS][NWAYS][BLK_WORDS];
    logic [SETS-1:0][NWAYS-1:0] valid_q, dirty_q;
    logic [SETS-1:0]            lru_q;

    // Sequencer state and latched request
    cstate_t           state;
    logic [TAG_W-1:0]  rq_tag, ev_tag_q;
    logic [SET_W-1:0]  rq_set;
    logic [OFF_WS-1:0] rq_off, beat_q;
    logic              rq_we, vic_q;
    logic [DATA_W-1:0] rq_wdata;

    // Address fields of the incoming request
    logic [TAG_W-1:0]  in_tag;
    logic [SET_W-1:0]  in_set;
    logic [OFF_WS-1:0] in_off;

    assign in_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign in_set = cpu_addr[OFF_W +: SET_W];
    if (OFF_W > 0) begin : g_off
        assign in_off = cpu_addr[OFF_WS-1:0];
    end else begin : g_no_off
        assign in_off = '0;
    end

    // Lookup of the indexed set
    logic [NWAYS-1:0][TAG_W-1:0] set_tags;
    logic [NWAYS-1:0]            way_hit;
    logic                        hit_any, hit_way, victim;

    // Gather the stored tags of the indexed set.
    always_comb begin
        for (int w = 0; w < NWAYS; w++) set_tags[w] = tag_q[in_set][w];
    end

    cache2w_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .tag_in   (in_tag),
        .set_tags (set_tags),
        .set_valid(valid_q[in_set]),
        .way_hit  (way_hit),
        .hit_any  (hit_any),
        .hit_way  (hit_way)
    );

    cache2w_victim u_vic (
        .set_valid(valid_q[in_set]),
        .lru_way  (lru_q[in_set]),
        .victim   (victim)
    );

    logic accept, last_beat;
    assign cpu_ready = (state == ST_IDLE);
    assign accept    = cpu_valid && cpu_ready;
    assign last_beat = (beat_q == OFF_WS'(BLK_WORDS - 1));

    function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                    input logic [SET_W-1:0] s,
                                                    input logic [OFF_WS-1:0] o);
        logic [TAG_W+SET_W+OFF_WS-1:0] wide;
        wide = {t, s, o};
        return ADDR_W'(wide >> (OFF_WS - OFF_W));
    endfunction

    // Memory port driven from the sequencer state.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_EVICT) || (state == ST_WTHRU);
        mem_addr  = join_addr(rq_tag, rq_set, beat_q);
        mem_wdata = rq_wdata;
        if (state == ST_EVICT) begin
            mem_addr  = join_addr(ev_tag_q, rq_set, beat_q);
            mem_wdata = data_q[rq_set][vic_q][beat_q];
        end else if (state == ST_WTHRU) begin
            mem_addr  = join_addr(rq_tag, rq_set, rq_off);
        end
    end

    // Data array write port: write hits and refill beats.
    logic              dw_en, dw_way;
    logic [SET_W-1:0]  dw_set;
    logic [OFF_WS-1:0] dw_off;
    logic [DATA_W-1:0] dw_din;
    always_comb begin
        dw_en  = 1'b0;
        dw_set = in_set;
        dw_way = hit_way;
        dw_off = in_off;
        dw_din = cpu_wdata;
        if (state == ST_IDLE && accept && hit_any && cpu_we) begin
            dw_en = 1'b1;
        end else if (state == ST_FILL && mem_ack) begin
            dw_en  = 1'b1;
            dw_set = rq_set;
            dw_way = vic_q;
            dw_off = beat_q;
            dw_din = (rq_we && beat_q == rq_off) ? rq_wdata : mem_rdata;
        end
    end

    // Data and tag storage, no reset needed.
    always_ff @(posedge clk) begin
        if (dw_en) data_q[dw_set][dw_way][dw_off] <= dw_din;
        if (state == ST_FILL && mem_ack && last_beat) tag_q[rq_set][vic_q] <= rq_tag;
    end

    // Sequencer, state bits, counters and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            valid_q    <= '0;
            dirty_q    <= '0;
            lru_q      <= '0;
            hit_count  <= '0;
            miss_count <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            rq_tag     <= '0;
            rq_set     <= '0;
            rq_off     <= '0;
            rq_we      <= 1'b0;
            rq_wdata   <= '0;
            vic_q      <= 1'b0;
            ev_tag_q   <= '0;
            beat_q     <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (cpu_valid) begin
                    rq_tag   <= in_tag;
                    rq_set   <= in_set;
                    rq_off   <= in_off;
                    rq_we    <= cpu_we;
                    rq_wdata <= cpu_wdata;
                    vic_q    <= victim;
                    ev_tag_q <= tag_q[in_set][victim];
                    beat_q   <= '0;
                    if (hit_any) begin
                        hit_count     <= hit_count + 1'b1;
                        lru_q[in_set] <= ~hit_way;
                        if (cpu_we && WRITE_BACK) dirty_q[in_set][hit_way] <= 1'b1;
                        if (cpu_we && !WRITE_BACK) begin
                            state <= ST_WTHRU;
                        end else begin
                            resp_valid <= 1'b1;
                            resp_rdata <= data_q[in_set][hit_way][in_off];
                        end
                    end else begin
                        miss_count <= miss_count + 1'b1;
                        if (cpu_we && !WRITE_BACK)
                            state <= ST_WTHRU;
                        else if (WRITE_BACK && valid_q[in_set][victim] && dirty_q[in_set][victim])
                            state <= ST_EVICT;
                        else
                            state <= ST_FILL;
                    end
                end
                ST_EVICT: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        beat_q <= '0;
                        state  <= ST_FILL;
                    end
                end
                ST_FILL: if (mem_ack) begin
                    if (beat_q == rq_off) resp_rdata <= mem_rdata;
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        valid_q[rq_set][vic_q] <= 1'b1;
                        dirty_q[rq_set][vic_q] <= WRITE_BACK && rq_we;
                        lru_q[rq_set]          <= ~vic_q;
                        resp_valid             <= 1'b1;
                        state                  <= ST_IDLE;
                    end
                end
                ST_WTHRU: if (mem_ack) begin
                    resp_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_single_way_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    p_hit_answers_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_any && !(cpu_we && !WRITE_BACK)) |=> (resp_valid && cpu_ready));

    p_count_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (CNT_W'(hit_count - $past(hit_count) + miss_count - $past(miss_count)) == CNT_W'(1)));

    p_count_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(hit_count) && $stable(miss_count)));

    p_mem_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(accept));

    p_no_dirty_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_FILL) |-> !(valid_q[rq_set][vic_q] && dirty_q[rq_set][vic_q]));

    p_fill_makes_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack && last_beat) |=> (lru_q[rq_set] != vic_q));

    if (WRITE_BACK) begin : g_wb_chk
        p_wb_mem_write_only_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we) |-> (state == ST_EVICT));
    end
endmodule

// File: tb/cache2w_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench memory: one-cycle acknowledge, read data with the acknowledge.
module cache2w_mem_model #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [1 << AW];
    initial begin
        for (int i = 0; i < (1 << AW); i++) cells[i] = DW'(i * 37 + 5);
        ack = 1'b0;
        rdata = '0;
    end
    always @(posedge clk) begin
        if (req && !ack) begin
            ack   <= 1'b1;
            rdata <= cells[addr];
            if (we) cells[addr] <= wdata;
        end else begin
            ack <= 1'b0;
        end
    end
endmodule

module cache2w_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // write-back instance (b) and write-through instance (t)
    logic        v_b, rdy_b, we_b, rv_b, mrq_b, mwe_b, mack_b;
    logic [7:0]  a_b, ma_b;
    logic [15:0] wd_b, rd_b, mwd_b, mrd_b, hc_b, mc_b;
    logic        v_t, rdy_t, we_t, rv_t, mrq_t, mwe_t, mack_t;
    logic [7:0]  a_t, ma_t;
    logic [15:0] wd_t, rd_t, mwd_t, mrd_t, hc_t, mc_t;

    cache2w_ctrl #(.WRITE_BACK(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(v_b), .cpu_ready(rdy_b), .cpu_we(we_b),
        .cpu_addr(a_b), .cpu_wdata(wd_b), .resp_valid(rv_b), .resp_rdata(rd_b),
        .mem_req(mrq_b), .mem_we(mwe_b), .mem_addr(ma_b), .mem_wdata(mwd_b),
        .mem_ack(mack_b), .mem_rdata(mrd_b), .hit_count(hc_b), .miss_count(mc_b));
    cache2w_mem_model mem_b_i (.clk(clk), .req(mrq_b), .we(mwe_b), .addr(ma_b),
        .wdata(mwd_b), .ack(mack_b), .rdata(mrd_b));

    cache2w_ctrl #(.WRITE_BACK(1'b0)) dut_wt_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(v_t), .cpu_ready(rdy_t), .cpu_we(we_t),
        .cpu_addr(a_t), .cpu_wdata(wd_t), .resp_valid(rv_t), .resp_rdata(rd_t),
        .mem_req(mrq_t), .mem_we(mwe_t), .mem_addr(ma_t), .mem_wdata(mwd_t),
        .mem_ack(mack_t), .mem_rdata(mrd_t), .hit_count(hc_t), .miss_count(mc_t));
    cache2w_mem_model mem_t_i (.clk(clk), .req(mrq_t), .we(mwe_t), .addr(ma_t),
        .wdata(mwd_t), .ack(mack_t), .rdata(mrd_t));

    int n_chk = 0, n_bad = 0;
    bit sel = 1'b0;              // 0 = write-back instance, 1 = write-through
    logic [15:0] gold [256];     // processor view of memory
    int rt [2][2];
    bit rvld [2][2];
    bit rlru [2];
    int acc_since_rst = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        v_b = 0; v_t = 0; we_b = 0; we_t = 0; a_b = 0; a_t = 0; wd_b = 0; wd_t = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 2; s++) begin
            rlru[s] = 0;
            for (int w = 0; w < 2; w++) begin rvld[s][w] = 0; rt[s][w] = 0; end
        end
        for (int i = 0; i < 256; i++) gold[i] = sel ? mem_t_i.cells[i] : mem_b_i.cells[i];
        acc_since_rst = 0;
    endtask

    // Bench reference for hit/miss under the stated replacement rules.
    function automatic bit ref_access(input bit we, input int a);
        int s = a % 2;
        int t = a / 2;
        int vw;
        for (int w = 0; w < 2; w++)
            if (rvld[s][w] && rt[s][w] == t) begin rlru[s] = (w == 0); return 1'b1; end
        if (we && sel) return 1'b0;
        vw = !rvld[s][0] ? 0 : (!rvld[s][1] ? 1 : int'(rlru[s]));
        rvld[s][vw] = 1; rt[s][vw] = t; rlru[s] = (vw == 0);
        return 1'b0;
    endfunction

    task automatic do_access(input bit we, input int a, input logic [15:0] wd,
                             output logic [15:0] rd, output bit hit, output int lat);
        logic [15:0] hc0;
        bit stall_ok = 1'b1;
        hc0 = sel ? hc_t : hc_b;
        @(negedge clk);
        if (sel) begin v_t = 1; we_t = we; a_t = 8'(a); wd_t = wd; end
        else     begin v_b = 1; we_b = we; a_b = 8'(a); wd_b = wd; end
        while (!(sel ? rdy_t : rdy_b)) @(negedge clk);
        @(negedge clk);
        v_b = 0; v_t = 0;
        lat = 1;
        while (!(sel ? rv_t : rv_b) && lat < 300) begin
            if (sel ? rdy_t : rdy_b) stall_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd  = sel ? rd_t : rd_b;
        hit = ((sel ? hc_t : hc_b) != hc0);
        acc_since_rst++;
        if (lat > 1) chk(stall_ok, "R11 ready low while miss pending", 0, 1);
    endtask

    logic [15:0] rd;
    bit hit;
    int lat;
    logic [15:0] lfsr = 16'hACE1;

    initial begin : main
        int trace_a [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
        bit exp_a [10]   = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
        int trace_b [5]  = '{0, 2, 0, 4, 2};
        bit exp_b [5]    = '{0, 0, 1, 0, 0};

        // R13: reset state
        do_reset();
        @(negedge clk);
        chk(rdy_b && rdy_t, "R13 ready after reset", int'(rdy_b), 1);
        chk(hc_b == 0 && mc_b == 0 && hc_t == 0 && mc_t == 0, "R13 counters cleared", int'(hc_b + mc_b), 0);
        chk(!rv_b && !rv_t && !mrq_b && !mrq_t, "R13 idle outputs", int'(rv_b), 0);

        // R14 trace A on both policies (reads only, so both match)
        for (int m = 0; m < 2; m++) begin
            sel = m[0];
            do_reset();
            for (int i = 0; i < 10; i++) begin
                do_access(0, trace_a[i], 0, rd, hit, lat);
                chk(hit == exp_a[i], "R14 trace A hit/miss (R3 R4 R5)", int'(hit), int'(exp_a[i]));
                chk(rd == gold[trace_a[i]], "R1 read data", int'(rd), int'(gold[trace_a[i]]));
                if (hit) chk(lat == 1, "R1 hit latency", lat, 1);
            end
            chk((sel ? hc_t : hc_b) == 2, "R12 hit count trace A", int'(sel ? hc_t : hc_b), 2);
            chk((sel ? mc_t : mc_b) == 8, "R12 miss count trace A", int'(sel ? mc_t : mc_b), 8);
        end

        // R14 trace B, after a reset that must have cleared all state (R13)
        sel = 0;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            do_access(0, trace_b[i], 0, rd, hit, lat);
            chk(hit == exp_b[i], "R14 trace B hit/miss (R13)", int'(hit), int'(exp_b[i]));
        end

        // R10/R6/R7: write-back allocate, dirty hold, eviction
        sel = 0;
        do_reset();
        do_access(1, 8, 16'hBEEF, rd, hit, lat);
        chk(!hit, "R10 write miss counted", int'(hit), 0);
        do_access(0, 8, 0, rd, hit, lat);
        chk(hit && rd == 16'hBEEF, "R10 merged word after allocate", int'(rd), 16'hBEEF);
        chk(mem_b_i.cells[8] == gold[8], "R6 memory untouched by allocate", int'(mem_b_i.cells[8]), int'(gold[8]));
        do_access(1, 8, 16'h1234, rd, hit, lat);
        chk(hit && lat == 1, "R6 write hit one-cycle", lat, 1);
        chk(mem_b_i.cells[8] == gold[8], "R6 write hit stays in cache", int'(mem_b_i.cells[8]), int'(gold[8]));
        do_access(0, 10, 0, rd, hit, lat);
        do_access(0, 12, 0, rd, hit, lat);
        chk(mem_b_i.cells[8] == 16'h1234, "R7 dirty victim written back", int'(mem_b_i.cells[8]), 16'h1234);
        do_access(0, 8, 0, rd, hit, lat);
        chk(!hit && rd == 16'h1234, "R7 refetched data", int'(rd), 16'h1234);

        // R8/R9: write-through
        sel = 1;
        do_reset();
        do_access(1, 6, 16'hA5A5, rd, hit, lat);
        chk(mem_t_i.cells[6] == 16'hA5A5, "R8 write miss reaches memory", int'(mem_t_i.cells[6]), 16'hA5A5);
        do_access(0, 6, 0, rd, hit, lat);
        chk(!hit, "R9 write miss did not allocate", int'(hit), 0);
        chk(rd == 16'hA5A5, "R8 read after write-through", int'(rd), 16'hA5A5);
        do_access(1, 6, 16'h5A5A, rd, hit, lat);
        chk(hit && mem_t_i.cells[6] == 16'h5A5A, "R8 write hit updates memory", int'(mem_t_i.cells[6]), 16'h5A5A);
        do_access(0, 6, 0, rd, hit, lat);
        chk(hit && rd == 16'h5A5A, "R8 write hit updates cache", int'(rd), 16'h5A5A);

        // Mixed sweep on both policies
        for (int m = 0; m < 2; m++) begin
            sel = m[0];
            do_reset();
            for (int i = 0; i < 400; i++) begin
                bit w;
                int a;
                bit eh;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = int'(lfsr[3:0]);
                w = (lfsr[9:8] == 2'b11);
                eh = ref_access(w, a);
                do_access(w, a, {lfsr[7:0], lfsr[15:8]}, rd, hit, lat);
                chk(hit == eh, "R2 R4 R5 sweep hit/miss", int'(hit), int'(eh));
                if (w) gold[a] = {lfsr[7:0], lfsr[15:8]};
                else chk(rd == gold[a], "R1 sweep read data", int'(rd), int'(gold[a]));
            end
            chk(int'(sel ? hc_t + mc_t : hc_b + mc_b) == acc_since_rst, "R12 sweep total",
                int'(sel ? hc_t + mc_t : hc_b + mc_b), acc_since_rst);
            if (sel)
                for (int i = 0; i < 16; i++)
                    chk(mem_t_i.cells[i] == gold[i], "R8 memory equals shadow", int'(mem_t_i.cells[i]), int'(gold[i]));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule